// File: doc/BRIEF.md
# GPIO Port Register Block with Bit-Masked Aliases

This block holds the control state of one eight-pin general-purpose I/O port. Three writable registers live in it: a pin-enable register that hands each pin to GPIO control, a direction register whose set bits make a pin drive, and an output-level register. A fourth register reports the pad levels after synchronization and can only be read. The block drives the pad output level, the pad drive enable and the per-pin GPIO enable from these registers. It also gives a per-pin readback level: the driven value for an output pin and the sampled value for an input pin.

Software reaches the registers over a simple word-wide bus with a byte address. Each writable register has two addresses. A write to the plain address replaces all eight bits. A write to the masked address changes only the bits that the upper byte of the data selects. Several ports can share one bus. Each instance answers only the addresses made from its own bank and port numbers, so the address carries the port select.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, the pin-enable, direction and output-level registers are all zero. `pad_oe`, `pad_out` and `gpio_en` are therefore 0, and every pin is a non-driving input.
- R2: A plain write replaces the addressed register with `bus_wdata[7:0]` at the clock edge where `bus_sel` and `bus_we` are high. `bus_wdata[31:8]` is ignored. Reads return the register in bits [7:0] with bits [31:8] zero.
- R3: A masked write updates register bit n to `bus_wdata[n]` only when `bus_wdata[8+n]` is 1. Every other bit keeps its value, and `bus_wdata[31:16]` is ignored.
- R4: The port base is BANK_ID*BANK_STRIDE + PORT_ID*4. Pin enable sits at base+0x00, direction at base+0x10, output level at base+0x20 and input at base+0x30. Each masked alias is its plain address plus UPPER_OFFSET.
- R5: An access to any other address, including an unaligned one, changes nothing, and a read of such an address returns zero. `bus_rdata` is zero whenever no read is in progress.
- R6: The input register shows `pad_in` through two flip-flops. A pad change made before rising edge k appears on a read after edge k+1, and not after edge k alone.
- R7: A plain or masked write to the input address has no effect on any register or output.
- R8: `gpio_en`, `pad_oe` and `pad_out` equal the pin-enable, direction and output-level registers. They change at the clock edge of the write.
- R9: `pin_level[n]` equals `pad_out[n]` when `pad_oe[n]` is 1. Otherwise it equals the synchronized input bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading this port |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive enables |
| gpio_en | output | 8 | Per-pin GPIO enable |
| pin_level | output | 8 | Per-pin readback level |

## Verification
The bench builds two instances on one shared bus. The first uses the default stride 0x80 and upper offset 0x800, with bank 1 and port 2. The second uses stride 0x100 and upper offset 0x80, with bank 2 and port 3. In the second layout the masked aliases sit inside the bank, close to the plain registers. With two instances on the bus, a write aimed at one port must leave the other unchanged, so a decode that ignores the bank or port field is exposed. Both address layouts are exercised, and a masked write is shown to stay within its own register.

// File: rtl/gpio_port_pkg.sv
// Shared types for the GPIO port register block.
// Assumes at most four register classes per port.
package gpio_port_pkg;

    // Register classes in address order; the offset is class * CLASS_STEP
    typedef enum logic [1:0] {
        CLS_EN  = 2'd0,
        CLS_DIR = 2'd1,
        CLS_LVL = 2'd2,
        CLS_IN  = 2'd3
    } reg_cls_e;

    localparam int unsigned CLASS_STEP = 16;
    localparam int unsigned NUM_CLASS  = 4;
    localparam int unsigned NUM_WR_REG = 3;

    // Decoded view of one bus address
    typedef struct packed {
        logic     hit;
        logic     masked;
        reg_cls_e cls;
    } dec_t;

    // Masked update: bits selected by en take val, the rest keep old
    function automatic logic [7:0] apply_mask(input logic [7:0] old,
                                              input logic [7:0] en,
                                              input logic [7:0] val);
        return (old & ~en) | (val & en);
    endfunction

endpackage

// File: rtl/gpio_port_dec.sv
// Address decoder for one port.
// Compares the bus address against every plain and masked register
// address of this bank/port and reports class and alias.
// Assumes the parameters place no two addresses on top of each other.
module gpio_port_dec #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned BANK_ID      = 1,
    parameter int unsigned PORT_ID      = 2,
    parameter int unsigned BANK_STRIDE  = 128,
    parameter int unsigned UPPER_OFFSET = 2048
) (
    input  logic [ADDR_W-1:0]  addr,
    output gpio_port_pkg::dec_t dec
);
    import gpio_port_pkg::*;

    localparam int unsigned BASE    = BANK_ID * BANK_STRIDE + PORT_ID * 4;
    localparam int unsigned N_MATCH = 2 * NUM_CLASS;

    logic [N_MATCH-1:0] match;

    // One comparator per (alias, class) pair
    for (genvar a = 0; a < 2; a++) begin : g_alias
        for (genvar c = 0; c < int'(NUM_CLASS); c++) begin : g_cls
            localparam int unsigned OFS = BASE + a * UPPER_OFFSET + c * CLASS_STEP;
            assign match[a*NUM_CLASS + c] = (addr == ADDR_W'(OFS));
        end
    end

    // Fold the one-hot match vector into a decoded record
    always_comb begin
        dec = '0;
        for (int i = 0; i < int'(N_MATCH); i++) begin
            if (match[i]) begin
                dec.hit    = 1'b1;
                dec.masked = (i >= int'(NUM_CLASS));
                dec.cls    = reg_cls_e'(2'(i % int'(NUM_CLASS)));
            end
        end
    end

endmodule

// File: rtl/gpio_mask_reg.sv
// One writable port register with plain and masked write paths.
// A plain write loads val; a masked write loads val only where en is set.
// Assumes at most one of the two write strobes is high per cycle.
module gpio_mask_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_plain,
    input  logic         wr_masked,
    input  logic [W-1:0] wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Select the next value from the two write paths
    always_comb begin
        nxt = q;
        if (wr_plain)
            nxt = wr_val;
        else if (wr_masked)
            nxt = (q & ~wr_en) | (wr_val & wr_en);
    end

    // Register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the pad inputs.
// Assumes each pad bit is handled on its own; no bus coherence is implied.
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
        // Shift one stage of the chain, cleared in reset
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[s] <= '0;
            else if (s == 0) stage[s] <= d;
            else             stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
// Top of the GPIO port register block.
// Decodes bus accesses for one bank/port, keeps the pin-enable, direction
// and output-level registers, synchronizes pad inputs and returns read data.
// Assumes a single-cycle bus: an access is one cycle of bus_sel.
module gpio_port_regs #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned BANK_ID      = 1,
    parameter int unsigned PORT_ID      = 2,
    parameter int unsigned BANK_STRIDE  = 128,
    parameter int unsigned UPPER_OFFSET = 2048,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe,
    output logic [7:0]        gpio_en,
    output logic [7:0]        pin_level
);
    import gpio_port_pkg::*;

    localparam int unsigned PW = 8;

    dec_t          dec;
    logic          wr_acc;
    logic          rd_acc;
    logic [PW-1:0] reg_q [NUM_WR_REG];
    logic [PW-1:0] in_q;
    logic          unused_upper;

    assign unused_upper = ^bus_wdata[31:16];

    gpio_port_dec #(
        .ADDR_W      (ADDR_W),
        .BANK_ID     (BANK_ID),
        .PORT_ID     (PORT_ID),
        .BANK_STRIDE (BANK_STRIDE),
        .UPPER_OFFSET(UPPER_OFFSET)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    assign wr_acc = bus_sel &  bus_we & dec.hit;
    assign rd_acc = bus_sel & ~bus_we & dec.hit;

    // One register per writable class; the input class has no storage here
    for (genvar r = 0; r < int'(NUM_WR_REG); r++) begin : g_reg
        logic sel_r;
        assign sel_r = wr_acc && (dec.cls == reg_cls_e'(2'(r)));
        gpio_mask_reg #(.W(PW)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_plain (sel_r & ~dec.masked),
            .wr_masked(sel_r &  dec.masked),
            .wr_en    (bus_wdata[2*PW-1:PW]),
            .wr_val   (bus_wdata[PW-1:0]),
            .q        (reg_q[r])
        );
    end

    gpio_in_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (in_q)
    );

    assign gpio_en = reg_q[CLS_EN];
    assign pad_oe  = reg_q[CLS_DIR];
    assign pad_out = reg_q[CLS_LVL];

    // Readback level: driven value for outputs, sampled value for inputs
    assign pin_level = (pad_oe & pad_out) | (~pad_oe & in_q);

    // Read data mux, zero-extended; both aliases read the same register
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (dec.cls)
                CLS_EN:  bus_rdata[PW-1:0] = reg_q[CLS_EN];
                CLS_DIR: bus_rdata[PW-1:0] = reg_q[CLS_DIR];
                CLS_LVL: bus_rdata[PW-1:0] = reg_q[CLS_LVL];
                CLS_IN:  bus_rdata[PW-1:0] = in_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_regs_chk.sv
// Property checker for gpio_port_regs, attached by bind.
// Observes the bus and the pad-side outputs only.
module gpio_port_regs_chk #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned BANK_ID      = 1,
    parameter int unsigned PORT_ID      = 2,
    parameter int unsigned BANK_STRIDE  = 128,
    parameter int unsigned UPPER_OFFSET = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        pad_in,
    input logic [7:0]        pad_out,
    input logic [7:0]        pad_oe,
    input logic [7:0]        gpio_en,
    input logic [7:0]        pin_level
);
    localparam int unsigned BASE = BANK_ID * BANK_STRIDE + PORT_ID * 4;
    localparam logic [ADDR_W-1:0] A_LVL_M = ADDR_W'(BASE + UPPER_OFFSET + 32);
    localparam logic [ADDR_W-1:0] A_IN_P  = ADDR_W'(BASE + 48);
    localparam logic [ADDR_W-1:0] A_IN_M  = ADDR_W'(BASE + UPPER_OFFSET + 48);

    logic [1:0] since_rst;

    // Count cycles since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == 8'h00 && pad_out == 8'h00 && gpio_en == 8'h00));

    // R3
    masked_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == A_LVL_M) |=>
        pad_out == ((($past(pad_out)) & ~($past(bus_wdata[15:8]))) |
                    (($past(bus_wdata[7:0])) & ($past(bus_wdata[15:8])))));

    // R7
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && (bus_addr == A_IN_P || bus_addr == A_IN_M)) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_en)));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_en)));

    // R9
    out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & pad_oe) == (pad_out & pad_oe));

    // R6
    in_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> ((pin_level & ~pad_oe) == ($past(pad_in, 2) & ~pad_oe)));

    // R5
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |-> bus_rdata == 32'h0);

    // R2
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:8] == 24'h0);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .ADDR_W      (ADDR_W),
    .BANK_ID     (BANK_ID),
    .PORT_ID     (PORT_ID),
    .BANK_STRIDE (BANK_STRIDE),
    .UPPER_OFFSET(UPPER_OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .gpio_en  (gpio_en),
    .pin_level(pin_level)
);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

    localparam int AW   = 12;
    localparam int A_BASE  = 1*128 + 2*4;   // 0x088
    localparam int A_UP    = 2048;
    localparam int B_BASE  = 2*256 + 3*4;   // 0x20C
    localparam int B_UP    = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata_a, rdata_b;
    logic [7:0]    pad_in_a = '0, pad_in_b = '0;
    logic [7:0]    out_a, oe_a, en_a, lvl_a;
    logic [7:0]    out_b, oe_b, en_b, lvl_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Models: index 0 enable, 1 direction, 2 output level
    logic [7:0] ma [3];
    logic [7:0] mb [3];

    always #2.5 clk = ~clk;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pad_in(pad_in_a), .pad_out(out_a), .pad_oe(oe_a), .gpio_en(en_a),
        .pin_level(lvl_a)
    );

    gpio_port_regs #(
        .ADDR_W(AW), .BANK_ID(2), .PORT_ID(3), .BANK_STRIDE(256), .UPPER_OFFSET(128)
    ) u_dut_b (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .pad_in(pad_in_b), .pad_out(out_b), .pad_oe(oe_b), .gpio_en(en_b),
        .pin_level(lvl_b)
    );

    function automatic logic [7:0] mupd(input logic [7:0] old, input logic [31:0] wd,
                                        input bit masked);
        if (!masked) return wd[7:0];
        return (old & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
    endfunction

    function automatic logic [7:0] plevel(input logic [7:0] oe, input logic [7:0] o,
                                          input logic [7:0] i);
        return (oe & o) | (~oe & i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int addr, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bread(input int addr, output logic [31:0] ra, output logic [31:0] rb);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        #1;
        ra = rdata_a; rb = rdata_b;
        bus_sel = 1'b0;
    endtask

    task automatic chk_ports(input string req);
        chk(req, {8'h0, en_a, oe_a, out_a}, {8'h0, ma[0], ma[1], ma[2]});
        chk(req, {8'h0, en_b, oe_b, out_b}, {8'h0, mb[0], mb[1], mb[2]});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb, wd;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) begin ma[k] = '0; mb[k] = '0; end
        pad_in_a = 8'hA5; pad_in_b = 8'h3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_ports("R1");

        // R2 plain write ignores upper bits, read is zero-extended
        bwrite(A_BASE + 32, 32'hDEAD_BE5A); ma[2] = 8'h5A;
        chk_ports("R2");
        bread(A_BASE + 32, ra, rb);
        chk("R2", ra, 32'h0000_005A);
        chk("R5", rb, 32'h0);

        // R3 masked write changes only enabled bits
        bwrite(A_BASE + A_UP + 32, 32'hFFFF_0F0F); ma[2] = 8'h5F;
        chk_ports("R3");
        bwrite(A_BASE + A_UP + 32, 32'h0000_0000);
        chk_ports("R3");

        // R4/R8 direction and enable through the second layout
        bwrite(B_BASE + 16, 32'h0000_00F0); mb[1] = 8'hF0;
        bwrite(B_BASE + B_UP + 0, 32'h0000_8181); mb[0] = 8'h81;
        chk_ports("R8");
        bread(B_BASE + B_UP + 16, ra, rb);
        chk("R4", rb, 32'h0000_00F0);
        chk("R4", ra, 32'h0);

        // R7 writes to the input address change nothing
        bwrite(A_BASE + 48, 32'h0000_00FF);
        bwrite(A_BASE + A_UP + 48, 32'h0000_FFFF);
        bwrite(B_BASE + B_UP + 48, 32'h0000_FFFF);
        chk_ports("R7");

        // R5 unaligned, off-port and unused-class addresses
        bwrite(A_BASE + 33, 32'h0000_00FF);
        bwrite(A_BASE + 64, 32'h0000_00FF);
        bwrite(A_BASE - 128 + 32, 32'h0000_00FF);
        bwrite(B_BASE + 4 + 32, 32'h0000_00FF);
        chk_ports("R5");
        bread(A_BASE + 33, ra, rb);
        chk("R5", ra, 32'h0);

        // R6 two-stage input timing
        @(negedge clk);
        pad_in_a = 8'h00;
        bread(A_BASE + 48, ra, rb);
        chk("R6", ra, 32'h0000_00A5);
        bread(A_BASE + 48, ra, rb);
        chk("R6", ra, 32'h0);
        bread(A_BASE + A_UP + 48, ra, rb);
        chk("R6", ra, 32'h0);

        // R9 readback mixes driven and sampled levels
        bwrite(A_BASE + 16, 32'h0000_000F); ma[1] = 8'h0F;
        pad_in_a = 8'hF0;
        repeat (3) @(negedge clk);
        chk("R9", lvl_a, plevel(ma[1], ma[2], 8'hF0));
        chk("R9", lvl_b, plevel(mb[1], mb[2], 8'h3C));

        // Random traffic over both ports, both aliases, all classes
        for (int i = 0; i < 400; i++) begin
            int  cls    = int'($urandom % 4);
            bit  masked = bit'($urandom % 2);
            bit  to_b   = bit'($urandom % 2);
            int  addr;
            wd = $urandom;
            addr = (to_b ? B_BASE : A_BASE) + (masked ? (to_b ? B_UP : A_UP) : 0) + cls*16;
            bwrite(addr, wd);
            if (cls != 3) begin
                if (to_b) mb[cls] = mupd(mb[cls], wd, masked);
                else      ma[cls] = mupd(ma[cls], wd, masked);
            end
            if (masked) chk_ports("R3");
            else        chk_ports("R2");
            if (i % 40 == 39) begin
                pad_in_a = 8'($urandom); pad_in_b = 8'($urandom);
                repeat (2) @(negedge clk);
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] ea, eb;
                    ea = (c == 3) ? pad_in_a : ma[c];
                    eb = (c == 3) ? pad_in_b : mb[c];
                    bread(A_BASE + A_UP + c*16, ra, rb);
                    chk("R4", ra, {24'h0, ea});
                    bread(B_BASE + c*16, ra, rb);
                    chk("R4", rb, {24'h0, eb});
                end
                chk("R9", lvl_a, plevel(ma[1], ma[2], pad_in_a));
                chk("R9", lvl_b, plevel(mb[1], mb[2], pad_in_b));
            end
        end

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin ma[k] = '0; mb[k] = '0; end
        @(negedge clk);
        chk_ports("R1");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule